// File: doc/BRIEF.md
# Programmable IO Sequencer

This block is a small single-issue engine that steps through a program of 16-bit instructions held in a 32-entry instruction store. It drives and samples a group of pins, and exchanges 32-bit words with a transmit queue and a receive queue through valid/ready handshakes. Its state is small: a program counter, two 32-bit scratch registers X and Y, an input shift register (ISR) and an output shift register (OSR), each with a bit counter, and a set of flag bits that other logic can see.

The program is written through a simple write port while `enable` is low. After that, one instruction completes per clock with no pipeline. Each instruction can ask for a number of idle cycles after it completes. Push, pull, wait and flag-wait instructions hold the machine on the same instruction until their condition is met, which makes it suitable for bit-banged protocols with exact cycle timing.

Top module: `io_sequencer`

## Requirements
- R1: During reset and right after it, pin_out, pin_oe and irq_flags are all zero and tx_pop and rx_push are low. X, Y, ISR and OSR are zero, the OSR counts as empty, and the program counter is 0.
- R2: The program is written through imem_we, imem_waddr and imem_wdata. While enable is low, no instruction executes and no output changes. When enable goes high, execution starts at the program counter, which is entry 0 after reset. Bits 15:13 hold the opcode: 000 jump, 001 wait, 010 shift-in, 011 shift-out, 100 push/pull, 101 move, 110 flag, 111 set.
- R3: Bits 12:8 hold a delay d. After an instruction completes, the machine idles for d clock cycles. An instruction that is stalled does not start its delay.
- R4: A jump takes its target from bits 4:0 and its condition from bits 7:5. The conditions are: 000 always; 001 X is zero; 010 X is nonzero, with X decremented whether or not the jump is taken; 011 Y is zero; 100 Y is nonzero, with Y decremented; 101 X differs from Y; 110 pin_in[JMP_PIN] is high; 111 the OSR is not empty.
- R5: For opcode 100, bit 7 selects the operation (0 push, 1 pull), bit 6 makes it conditional, and bit 5 makes it blocking. A conditional push only acts when the ISR holds 32 bits. A conditional pull only acts when the OSR is empty. A blocking pull stalls while tx_valid is low, and a blocking push stalls while rx_ready is low. tx_pop is asserted only together with tx_valid, and rx_push only together with rx_ready, with the ISR presented on rx_data. A push clears the ISR and its count. A pull loads tx_data into the OSR and zeroes its shift count.
- R6: A non-blocking pull while tx_valid is low loads X into the OSR.
- R7: For shift-in, bits 7:5 select the source: 000 pins (zero-extended), 001 X, 010 Y, anything else zeros. The count n comes from bits 4:0, where 0 means 32. The ISR becomes (ISR << n) OR the low n bits of the source.
- R8: For shift-out, the low n bits of the OSR go to the destination in bits 7:5: 000 pin_out, 001 X, 010 Y, 101 program counter, anything else discarded. The OSR then shifts right by n. The OSR is empty once 32 bits have been shifted out since the last load.
- R9: For move, bits 7:5 select the destination: 000 pins, 001 X, 010 Y, 101 program counter, 110 ISR, 111 OSR. Writing the ISR or the OSR resets its count. Bits 4:3 select the operation: 00 copy, 01 invert, 10 bit-reverse. Bits 2:0 select the source: 000 pins, 001 X, 010 Y, 110 ISR, 111 OSR, anything else zero.
- R10: For set, the 5-bit value in bits 4:0 is zero-extended and written to the destination in bits 7:5: 000 pin_out, 001 X, 010 Y, 100 pin_oe.
- R11: A wait instruction stalls until pin_in[bits 4:0] equals the polarity in bit 7.
- R12: For the flag instruction, bits 2:0 pick an irq_flags bit. With bit 6 set, the instruction clears that bit. Otherwise it sets the bit, and if bit 5 is also set it stalls until the bit has been cleared again. Any bit set in irq_clear clears the matching flag.
- R13: The program counter increments from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the program while high |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | 5 | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to write |
| pin_in | input | N_PINS | Sampled pin levels |
| pin_out | output | N_PINS | Driven pin levels |
| pin_oe | output | N_PINS | Pin output enables |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Word taken from the transmit queue this cycle |
| rx_ready | input | 1 | Receive queue has space |
| rx_data | output | 32 | Word offered to the receive queue |
| rx_push | output | 1 | Word written to the receive queue this cycle |
| irq_clear | input | N_IRQ | Per-flag clear strobes |
| irq_flags | output | N_IRQ | Flag bits |

## Verification
The only visible state is pin levels, queue handshakes and flags, so a wrong X, Y or shift register stays hidden until a push shows it on rx_data. The bench therefore ends each program with a push of the register under test. A wrong program counter or delay count shows as a push that arrives in the wrong cycle, so the loop test counts the exact cycle of the push from the moment of enable. A stall that fails to hold shows as an early push, pin change or pop, which the bench looks for while the blocking condition is held.

// File: rtl/ioseq_pkg.sv
package ioseq_pkg;

  typedef enum logic [2:0] {
    OP_JMP  = 3'd0,
    OP_WAIT = 3'd1,
    OP_IN   = 3'd2,
    OP_OUT  = 3'd3,
    OP_PP   = 3'd4,
    OP_MOV  = 3'd5,
    OP_IRQ  = 3'd6,
    OP_SET  = 3'd7
  } opcode_e;

  // A 5-bit count field; zero stands for a full word
  function automatic logic [5:0] bit_count(input logic [4:0] f);
    return (f == 5'd0) ? 6'd32 : {1'b0, f};
  endfunction

  function automatic logic [31:0] low_mask(input logic [5:0] n);
    return (n >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // New bits enter the ISR at the bottom
  function automatic logic [31:0] shift_in(input logic [31:0] isr, input logic [31:0] src,
                                           input logic [5:0] n);
    return (n >= 6'd32) ? src : ((isr << n) | (src & low_mask(n)));
  endfunction

  // What stays in the OSR after its low n bits leave
  function automatic logic [31:0] shift_rest(input logic [31:0] osr, input logic [5:0] n);
    return (n >= 6'd32) ? 32'd0 : (osr >> n);
  endfunction

  function automatic logic [5:0] sat_add(input logic [5:0] cnt, input logic [5:0] n);
    logic [6:0] s;
    s = {1'b0, cnt} + {1'b0, n};
    return (s > 7'd32) ? 6'd32 : s[5:0];
  endfunction

endpackage

// File: rtl/ioseq_imem.sv
module ioseq_imem #(
  parameter int AW = 5,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/ioseq_delay.sv
module ioseq_delay #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (load)            left_q <= load_val;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/ioseq_cond.sv
module ioseq_cond (
  input  logic [2:0]  cond,
  input  logic [31:0] x,
  input  logic [31:0] y,
  input  logic        pin,
  input  logic        osr_empty,
  output logic        take
);
  always_comb begin
    case (cond)
      3'd0:    take = 1'b1;
      3'd1:    take = (x == 32'd0);
      3'd2:    take = (x != 32'd0);
      3'd3:    take = (y == 32'd0);
      3'd4:    take = (y != 32'd0);
      3'd5:    take = (x != y);
      3'd6:    take = pin;
      default: take = !osr_empty;
    endcase
  end
endmodule

// File: rtl/io_sequencer.sv
module io_sequencer
  import ioseq_pkg::*;
#(
  parameter int N_PINS  = 8,
  parameter int JMP_PIN = 0,
  parameter int N_IRQ   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              imem_we,
  input  logic [4:0]        imem_waddr,
  input  logic [15:0]       imem_wdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  input  logic              tx_valid,
  input  logic [31:0]       tx_data,
  output logic              tx_pop,
  input  logic              rx_ready,
  output logic [31:0]       rx_data,
  output logic              rx_push,
  input  logic [N_IRQ-1:0]  irq_clear,
  output logic [N_IRQ-1:0]  irq_flags
);
  localparam int AW   = 5;
  localparam int IW   = 16;
  localparam int PINW = $clog2(N_PINS);
  localparam int IRQW = $clog2(N_IRQ);

  logic [AW-1:0]     pc_q, pc_next;
  logic [31:0]       x_q, y_q, isr_q, osr_q;
  logic [5:0]        isr_cnt_q, osr_cnt_q;
  logic [N_PINS-1:0] pins_q, dirs_q;
  logic [N_IRQ-1:0]  flags_q, flags_d;
  logic              irq_pend_q, irq_pend_d;

  // Fetch and field split
  logic [IW-1:0] instr;
  opcode_e       op;
  logic [4:0]    dly, arg;
  logic [2:0]    fld;
  logic [5:0]    nbits;

  ioseq_imem #(.AW(AW), .IW(IW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc_q), .rdata(instr)
  );

  assign op    = opcode_e'(instr[15:13]);
  assign dly   = instr[12:8];
  assign fld   = instr[7:5];
  assign arg   = instr[4:0];
  assign nbits = bit_count(arg);

  // Named internal events
  logic delay_busy, run, stall_now, step_done, jmp_take;

  ioseq_delay #(.W(5)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(step_done), .load_val(dly), .busy(delay_busy)
  );

  ioseq_cond u_cond (
    .cond(fld), .x(x_q), .y(y_q), .pin(pin_in[JMP_PIN]),
    .osr_empty(osr_cnt_q == 6'd32), .take(jmp_take)
  );

  // Operand selection
  logic [31:0] pins32, arg32, in_src, mov_src, mov_val, out_data;
  assign pins32   = 32'(pin_in);
  assign arg32    = {27'd0, arg};
  assign out_data = osr_q & low_mask(nbits);

  always_comb begin
    case (fld)
      3'd0:    in_src = pins32;
      3'd1:    in_src = x_q;
      3'd2:    in_src = y_q;
      default: in_src = 32'd0;
    endcase
    case (arg[2:0])
      3'd0:    mov_src = pins32;
      3'd1:    mov_src = x_q;
      3'd2:    mov_src = y_q;
      3'd6:    mov_src = isr_q;
      3'd7:    mov_src = osr_q;
      default: mov_src = 32'd0;
    endcase
    case (arg[4:3])
      2'd1:    mov_val = ~mov_src;
      2'd2:    mov_val = rev32(mov_src);
      default: mov_val = mov_src;
    endcase
  end

  // Push/pull and flag field decode
  logic pp_pull, pp_cond, pp_block, do_push, do_pull, wait_ok;
  logic irq_clr, irq_wait;
  logic [IRQW-1:0] irq_idx;

  assign pp_pull  = fld[2];
  assign pp_cond  = fld[1];
  assign pp_block = fld[0];
  assign do_push  = !pp_pull && (!pp_cond || isr_cnt_q == 6'd32);
  assign do_pull  = pp_pull && (!pp_cond || osr_cnt_q == 6'd32);
  assign wait_ok  = (pin_in[arg[PINW-1:0]] == fld[2]);
  assign irq_clr  = fld[1];
  assign irq_wait = fld[0];
  assign irq_idx  = arg[IRQW-1:0];

  always_comb begin
    case (op)
      OP_WAIT: stall_now = !wait_ok;
      OP_PP:   stall_now = (do_pull && pp_block && !tx_valid) ||
                           (do_push && pp_block && !rx_ready);
      OP_IRQ:  stall_now = !irq_clr && irq_wait && (!irq_pend_q || flags_q[irq_idx]);
      default: stall_now = 1'b0;
    endcase
  end

  assign run       = enable && !delay_busy;
  assign step_done = run && !stall_now;
  assign tx_pop    = step_done && (op == OP_PP) && do_pull && tx_valid;
  assign rx_push   = step_done && (op == OP_PP) && do_push && rx_ready;
  assign rx_data   = isr_q;

  always_comb begin
    pc_next = pc_q + 1'b1;
    if (op == OP_JMP && jmp_take)              pc_next = arg;
    else if (op == OP_OUT && fld == 3'd5)      pc_next = out_data[AW-1:0];
    else if (op == OP_MOV && fld == 3'd5)      pc_next = mov_val[AW-1:0];
  end

  always_comb begin
    flags_d    = flags_q & ~irq_clear;
    irq_pend_d = irq_pend_q;
    if (run && op == OP_IRQ) begin
      if (irq_clr) begin
        flags_d[irq_idx] = 1'b0;
      end else begin
        if (!irq_wait || !irq_pend_q) flags_d[irq_idx] = 1'b1;
        if (irq_wait) irq_pend_d = !step_done;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;  x_q <= '0;  y_q <= '0;  isr_q <= '0;  osr_q <= '0;
      isr_cnt_q <= '0;  osr_cnt_q <= 6'd32;
      pins_q <= '0;  dirs_q <= '0;  flags_q <= '0;  irq_pend_q <= 1'b0;
    end else begin
      flags_q    <= flags_d;
      irq_pend_q <= irq_pend_d;
      if (step_done) begin
        pc_q <= pc_next;
        case (op)
          OP_JMP: begin
            if (fld == 3'd2)      x_q <= x_q - 32'd1;
            else if (fld == 3'd4) y_q <= y_q - 32'd1;
          end
          OP_IN: begin
            isr_q     <= shift_in(isr_q, in_src, nbits);
            isr_cnt_q <= sat_add(isr_cnt_q, nbits);
          end
          OP_OUT: begin
            osr_q     <= shift_rest(osr_q, nbits);
            osr_cnt_q <= sat_add(osr_cnt_q, nbits);
            case (fld)
              3'd0:    pins_q <= out_data[N_PINS-1:0];
              3'd1:    x_q    <= out_data;
              3'd2:    y_q    <= out_data;
              default: ;
            endcase
          end
          OP_PP: begin
            if (do_push) begin
              isr_q     <= '0;
              isr_cnt_q <= '0;
            end
            if (do_pull) begin
              osr_q     <= tx_valid ? tx_data : x_q;
              osr_cnt_q <= '0;
            end
          end
          OP_MOV: begin
            case (fld)
              3'd0:    pins_q <= mov_val[N_PINS-1:0];
              3'd1:    x_q    <= mov_val;
              3'd2:    y_q    <= mov_val;
              3'd6:    begin isr_q <= mov_val; isr_cnt_q <= '0; end
              3'd7:    begin osr_q <= mov_val; osr_cnt_q <= '0; end
              default: ;
            endcase
          end
          OP_SET: begin
            case (fld)
              3'd0:    pins_q <= arg32[N_PINS-1:0];
              3'd1:    x_q    <= arg32;
              3'd2:    y_q    <= arg32;
              3'd4:    dirs_q <= arg32[N_PINS-1:0];
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign pin_out   = pins_q;
  assign pin_oe    = dirs_q;
  assign irq_flags = flags_q;
endmodule

// File: rtl/ioseq_chk.sv
module ioseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       tx_pop,
  input logic       tx_valid,
  input logic       rx_push,
  input logic       rx_ready,
  input logic [4:0] pc_q,
  input logic       step_done,
  input logic       delay_busy
);
  // R3
  delay_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_busy |-> (!tx_pop && !rx_push));

  // R3
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_busy |=> $stable(pc_q));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(pc_q));

  // R5
  push_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_ready);

  // R5
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !delay_busy && !step_done) |=> $stable(pc_q));
endmodule

bind io_sequencer ioseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_pop(tx_pop), .tx_valid(tx_valid),
  .rx_push(rx_push), .rx_ready(rx_ready), .pc_q(pc_q), .step_done(step_done),
  .delay_busy(delay_busy)
);

// File: tb/tb_io_sequencer.sv
module tb_io_sequencer;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, enable, imem_we, tx_valid, tx_pop, rx_ready, rx_push;
  logic [4:0]  imem_waddr;
  logic [15:0] imem_wdata;
  logic [7:0]  pin_in, pin_out, pin_oe, irq_clear, irq_flags;
  logic [31:0] tx_data, rx_data;

  io_sequencer #(.N_PINS(8), .JMP_PIN(0), .N_IRQ(8)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_push(rx_push), .irq_clear(irq_clear), .irq_flags(irq_flags)
  );

  int checks = 0, fails = 0, tick = 0;
  logic [31:0] txb [16];
  logic [31:0] rxb [16];
  int rx_tick [16];
  int tx_wr, tx_rd, rx_n;
  bit rnd_tx, rnd_rx, en_nxt;
  logic [7:0]  clr_nxt;
  logic [15:0] prog [32];

  function automatic logic [15:0] enc(int op, int d, int f, int a);
    return {op[2:0], d[4:0], f[2:0], a[4:0]};
  endfunction

  function automatic logic [31:0] flip(logic [31:0] v);
    return {<<{v}};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive queue sides at the falling edge, then record handshakes
  task automatic step();
    @(negedge clk);
    enable    = en_nxt;
    irq_clear = clr_nxt;
    tx_valid  = (tx_rd < tx_wr) && (!rnd_tx || ($urandom_range(0, 1) == 1));
    tx_data   = tx_valid ? txb[tx_rd] : 32'd0;
    rx_ready  = !rnd_rx || ($urandom_range(0, 3) != 0);
    #1;
    tick++;
    if (tx_pop) tx_rd++;
    if (rx_push && rx_n < 16) begin
      rxb[rx_n] = rx_data;
      rx_tick[rx_n] = tick;
      rx_n++;
    end
    if (tick > LIMIT) begin
      fails++;
      $display("FAIL R2 watchdog: actual tick %0d expected below %0d", tick, LIMIT);
      summary();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; en_nxt = 1'b0; clr_nxt = '0; irq_clear = '0;
    imem_we = 1'b0; tx_valid = 1'b0; rx_ready = 1'b1; tx_data = '0;
    tx_wr = 0; tx_rd = 0; rx_n = 0; rnd_tx = 0; rnd_rx = 0;
    for (int i = 0; i < 16; i++) rxb[i] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = enc(0, 0, 0, i);
  endtask

  task automatic load();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = i[4:0]; imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic wait_rx(int n, int maxc);
    for (int k = 0; k < maxc && rx_n < n; k++) step();
  endtask

  initial begin
    logic [31:0] a [3];
    logic [31:0] b [3];
    logic [31:0] w;
    int start;
    void'($urandom(32'd8812));
    pin_in = 8'h00; imem_waddr = '0; imem_wdata = '0;

    // Reset state
    do_reset();
    step();
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 irq_flags", 32'(irq_flags), 0);
    chk("R1 handshakes", {30'd0, tx_pop, rx_push}, 0);

    // Program A: loop with delay, X-- exit, set destinations
    clear_prog();
    prog[0] = enc(7, 0, 4, 31);   // pin_oe = 1F
    prog[1] = enc(7, 0, 1, 3);    // X = 3
    prog[2] = enc(7, 2, 0, 5);    // pins = 5, delay 2
    prog[3] = enc(7, 0, 0, 10);   // pins = 10
    prog[4] = enc(0, 0, 2, 2);    // jump if X nonzero, X--
    prog[5] = enc(2, 0, 1, 0);    // shift-in X, 32 bits
    prog[6] = enc(4, 0, 1, 0);    // blocking push
    prog[7] = enc(0, 0, 0, 7);
    load();
    repeat (5) step();
    chk("R2 idle while disabled", 32'(pin_oe), 0);
    en_nxt = 1'b1;
    step();
    start = tick;
    wait_rx(1, 100);
    chk("R4 X after exit", rxb[0], 32'hFFFF_FFFF);
    chk("R3 push cycle", rx_tick[0] - start, 23);
    chk("R10 pin_oe", 32'(pin_oe), 32'h1F);
    chk("R10 pin_out", 32'(pin_out), 32'h0A);

    // Program B: random words, pulls/outs, move ops, shift-in; random queue gating
    do_reset();
    clear_prog();
    prog[0]  = enc(4, 0, 5, 0);        // blocking pull
    prog[1]  = enc(3, 0, 1, 0);        // out X, 32
    prog[2]  = enc(4, 0, 5, 0);
    prog[3]  = enc(3, 0, 2, 0);        // out Y, 32
    prog[4]  = enc(5, 0, 6, 5'b01001); // ISR = ~X
    prog[5]  = enc(4, 0, 1, 0);
    prog[6]  = enc(5, 0, 6, 5'b10010); // ISR = reverse(Y)
    prog[7]  = enc(4, 0, 1, 0);
    prog[8]  = enc(2, 0, 1, 8);        // in X, 8
    prog[9]  = enc(2, 0, 2, 8);        // in Y, 8
    prog[10] = enc(4, 0, 1, 0);
    prog[11] = enc(0, 0, 0, 0);
    load();
    for (int i = 0; i < 3; i++) begin
      a[i] = $urandom; b[i] = $urandom;
      txb[2*i] = a[i]; txb[2*i+1] = b[i];
    end
    tx_wr = 6; rnd_tx = 1; rnd_rx = 1;
    en_nxt = 1'b1;
    wait_rx(9, 3000);
    for (int i = 0; i < 3; i++) begin
      chk("R9 invert X", rxb[3*i], ~a[i]);
      chk("R9 reverse Y", rxb[3*i+1], flip(b[i]));
      chk("R7 two 8-bit shifts", rxb[3*i+2], {16'd0, a[i][7:0], b[i][7:0]});
    end
    repeat (20) step();
    chk("R5 stall on empty tx", 32'(rx_n), 9);
    chk("R5 words popped", 32'(tx_rd), 6);

    // Program C: wait on pin, non-blocking pull, flag wait, jump conditions
    do_reset();
    clear_prog();
    prog[0]  = enc(1, 0, 4, 3);        // wait pin 3 high
    prog[1]  = enc(7, 0, 1, 21);       // X = 21
    prog[2]  = enc(4, 0, 4, 0);        // non-blocking pull
    prog[3]  = enc(5, 0, 6, 5'b00111); // ISR = OSR
    prog[4]  = enc(4, 0, 1, 0);
    prog[5]  = enc(6, 0, 1, 2);        // set flag 2 and wait
    prog[6]  = enc(7, 0, 0, 7);        // pins = 7
    prog[7]  = enc(0, 0, 7, 10);       // jump if OSR not empty
    prog[8]  = enc(7, 0, 1, 1);
    prog[9]  = enc(0, 0, 0, 11);
    prog[10] = enc(7, 0, 1, 2);
    prog[11] = enc(5, 0, 6, 5'b00001); // ISR = X
    prog[12] = enc(4, 0, 1, 0);
    prog[13] = enc(0, 0, 6, 16);       // jump if pin high
    prog[14] = enc(7, 0, 2, 4);
    prog[15] = enc(0, 0, 0, 17);
    prog[16] = enc(7, 0, 2, 6);
    prog[17] = enc(5, 0, 6, 5'b00010); // ISR = Y
    prog[18] = enc(4, 0, 1, 0);
    prog[19] = enc(0, 0, 0, 19);
    load();
    pin_in = 8'h01;
    en_nxt = 1'b1;
    repeat (10) step();
    chk("R11 held by wait", 32'(rx_n), 0);
    pin_in = 8'h09;
    wait_rx(1, 50);
    chk("R6 X copied on empty pull", rxb[0], 32'd21);
    repeat (5) step();
    chk("R12 flag set", 32'(irq_flags), 32'h04);
    chk("R12 stalled on flag", 32'(pin_out), 0);
    clr_nxt = 8'h04;
    step();
    clr_nxt = 8'h00;
    repeat (4) step();
    chk("R12 resumed", 32'(pin_out), 32'h07);
    chk("R12 flag cleared", 32'(irq_flags), 0);
    wait_rx(3, 100);
    chk("R4 OSR not empty taken", rxb[1], 32'd2);
    chk("R4 pin taken", rxb[2], 32'd6);

    // Program D: wrap from 31 to 0, shift-out to pins
    for (int r = 0; r < 3; r++) begin
      do_reset();
      clear_prog();
      prog[0]  = enc(0, 0, 3, 29);       // jump if Y zero
      prog[1]  = enc(5, 0, 6, 5'b00111); // ISR = OSR
      prog[2]  = enc(4, 0, 1, 0);
      prog[3]  = enc(0, 0, 0, 3);
      prog[29] = enc(4, 0, 5, 0);        // blocking pull
      prog[30] = enc(3, 0, 0, 4);        // out pins, 4
      prog[31] = enc(7, 0, 2, 1);        // Y = 1
      load();
      w = $urandom;
      txb[0] = w; tx_wr = 1;
      en_nxt = 1'b1;
      wait_rx(1, 100);
      chk("R13 wrap then push rest", rxb[0], w >> 4);
      chk("R8 low bits on pins", 32'(pin_out), {28'd0, w[3:0]});
    end

    summary();
  end
endmodule